// File: doc/BRIEF.md
# Interrupt Router Indirect Register Window

This block is the memory-mapped front end of an interrupt router. Software cannot reach the router's internal registers directly. It writes an 8-bit index into a select location, then reads or writes a 32-bit data window. The register the window reaches depends on the index. Behind the window are a 4-bit unit identifier, a fixed read-only version word, an arbitration word that always reads zero, and a table of 64-bit redirection entries, one per interrupt pin.

Each table entry is reached as two 32-bit halves. Two consecutive select indices form a pair for one entry. The parity of the index picks the half: even reaches the low half and odd reaches the high half. A write to one half merges with the half that is already stored. Every write that lands on a valid entry is passed on to the delivery engine, one cycle later, in two ways: the entry's full merged 64-bit value on an update port, and a strobe that asks the engine to re-evaluate pending interrupts.

Accesses are single-beat, one per cycle. Only the low 8 address bits are decoded. Read data comes back registered, one cycle after the access.

Top module: `irq_regwin`

## Requirements
- R1: The select location is at address offset 0x00 and the data window is at offset 0x10. Only `acc_addr[7:0]` is decoded, so an address such as 0x110 behaves as 0x10.
- R2: A write to offset 0x00 stores `acc_wdata[7:0]` as the 8-bit select value. A read of offset 0x00 returns the select value zero-extended to 32 bits.
- R3: With select index 0x00, a window write stores `acc_wdata[27:24]` as the 4-bit ID. A window read returns the ID in bits 27:24 and zeros in all other bits.
- R4: With select index 0x01, a window read returns 0x11 in bits 7:0, the value NPINS-1 in bits 23:16 (0x00170011 for 24 pins), and zeros elsewhere. Window writes with this index change nothing.
- R5: With select index 0x02, or any index from 0x03 to 0x0F, a window read returns 0. Window writes with these indices change nothing.
- R6: For a select index s ≥ 0x10, the entry number is (s−0x10)/2. An even s reaches entry bits 31:0 and an odd s reaches bits 63:32, for both reads and writes.
- R7: A write to one half of an entry leaves the other half of that entry unchanged. It also leaves every other entry unchanged.
- R8: For select indices at or beyond 0x10+2·NPINS (0x40 for 24 pins), the entry number is out of range. Window reads return 0, and window writes change no entry and raise neither the update port nor the re-evaluate strobe.
- R9: In the cycle after an in-range entry write, `ent_upd_valid` and `reeval_pulse` are high for exactly one cycle. In that same cycle, `ent_upd_idx` carries the entry number and `ent_upd_value` carries the merged 64-bit entry.
- R10: After reset, the ID is 0, the select value is 0, and every entry reads 0x0000_0000_0001_0000 (only bit 16, the mask bit, set).
- R11: Reads of any offset other than 0x00 and 0x10 return 0. Writes to such offsets change no state.
- R12: Read data appears on `acc_rdata` in the cycle after the read access. In any cycle that does not follow a read access, `acc_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data, valid one cycle after a read |
| ent_upd_valid | output | 1 | A table entry was written in the previous cycle |
| ent_upd_idx | output | $clog2(NPINS) | Number of the entry that was written |
| ent_upd_value | output | 64 | Merged 64-bit value of that entry |
| reeval_pulse | output | 1 | Request for the delivery engine to re-evaluate pending interrupts |

## Verification
A wrong select value or a wrong half choice shows as a wrong word on the next window read. It also shows in the cycle after the next entry write, as a wrong index or a wrong merged value on the update port. A corrupted stored half stays hidden until that entry is read or its other half is written. At that point the merged value on the update port exposes it in the same cycle as the strobe. A faulty decode that lets read-only or out-of-range writes through shows as a spurious strobe one cycle after the access, or as changed data on a later readback.

// File: rtl/irqwin_pkg.sv
package irqwin_pkg;
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_ENT
    } tgt_e;

    localparam logic [7:0] OFS_SEL      = 8'h00;
    localparam logic [7:0] OFS_WIN      = 8'h10;
    localparam logic [7:0] IDX_ID       = 8'h00;
    localparam logic [7:0] IDX_VER      = 8'h01;
    localparam logic [7:0] IDX_ARB      = 8'h02;
    localparam logic [7:0] IDX_ENT_BASE = 8'h10;
    localparam logic [7:0] VER_CODE     = 8'h11;
    localparam int         ID_LSB       = 24;
    localparam int         ID_W         = 4;
    localparam int         MASK_BIT     = 16;
endpackage

// File: rtl/irqwin_decode.sv
module irqwin_decode
    import irqwin_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = $clog2(NPINS)
) (
    input  logic [7:0]       sel,
    output tgt_e             tgt,
    output logic [IDX_W-1:0] ent_idx,
    output logic             ent_hi
);
    logic [7:0] rel;
    logic [6:0] ent_num;

    always_comb begin
        rel     = sel - IDX_ENT_BASE;
        ent_num = rel[7:1];
        ent_hi  = rel[0];
        ent_idx = ent_num[IDX_W-1:0];
        if (sel == IDX_ID)
            tgt = TGT_ID;
        else if (sel == IDX_VER)
            tgt = TGT_VER;
        else if (sel == IDX_ARB)
            tgt = TGT_ARB;
        else if (sel >= IDX_ENT_BASE && 32'(ent_num) < NPINS)
            tgt = TGT_ENT;
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/irqwin_table.sv
module irqwin_table
    import irqwin_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic             hi,
    input  logic [31:0]      wr_word,
    output logic [31:0]      rd_word,
    output logic [63:0]      merged
);
    localparam logic [63:0] ENT_RST = 64'(1) << MASK_BIT;

    logic [NPINS-1:0][63:0] ent_d, ent_q;
    logic [63:0]            cur;

    always_comb begin
        cur = '0;
        if (32'(idx) < NPINS)
            cur = ent_q[idx];
        merged  = hi ? {wr_word, cur[31:0]} : {cur[63:32], wr_word};
        rd_word = hi ? cur[63:32] : cur[31:0];
        ent_d   = ent_q;
        if (wr_en && 32'(idx) < NPINS)
            ent_d[idx] = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPINS; i++)
                ent_q[i] <= ENT_RST;
        end else begin
            ent_q <= ent_d;
        end
    end

    // R7: no write leaves the whole table untouched
    assert_table_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ent_q == $past(ent_q));
    // R7: a high-half write keeps the stored low half
    assert_keep_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hi && 32'(idx) < NPINS) |=> ent_q[$past(idx)][31:0] == $past(cur[31:0]));
    // R7: a low-half write keeps the stored high half
    assert_keep_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hi && 32'(idx) < NPINS) |=> ent_q[$past(idx)][63:32] == $past(cur[63:32]));
endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
    import irqwin_pkg::*;
#(
    parameter int NPINS  = 24,
    parameter int ADDR_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       acc_valid,
    input  logic                       acc_write,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [31:0]                acc_wdata,
    output logic [31:0]                acc_rdata,
    output logic                       ent_upd_valid,
    output logic [$clog2(NPINS)-1:0]   ent_upd_idx,
    output logic [63:0]                ent_upd_value,
    output logic                       reeval_pulse
);
    localparam int IDX_W = $clog2(NPINS);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VER_CODE};

    typedef struct packed {
        logic [7:0]       sel;
        logic [ID_W-1:0]  id;
        logic [31:0]      rdata;
        logic             upd_v;
        logic [IDX_W-1:0] upd_idx;
        logic [63:0]      upd_val;
        logic             reeval;
    } state_t;

    state_t st_d, st_q;

    logic [7:0]       ofs;
    logic             hit_sel, hit_win, rd_acc, wr_acc, tbl_we;
    tgt_e             tgt;
    logic [IDX_W-1:0] ent_idx;
    logic             ent_hi;
    logic [31:0]      tbl_rd;
    logic [63:0]      tbl_merged;
    logic             unused_addr_hi;

    assign ofs            = acc_addr[7:0];
    assign unused_addr_hi = ^acc_addr;
    assign hit_sel        = (ofs == OFS_SEL);
    assign hit_win        = (ofs == OFS_WIN);
    assign rd_acc         = acc_valid && !acc_write;
    assign wr_acc         = acc_valid && acc_write;
    assign tbl_we         = wr_acc && hit_win && (tgt == TGT_ENT);

    irqwin_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_decode (
        .sel     (st_q.sel),
        .tgt     (tgt),
        .ent_idx (ent_idx),
        .ent_hi  (ent_hi)
    );

    irqwin_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .idx     (ent_idx),
        .hi      (ent_hi),
        .wr_word (acc_wdata),
        .rd_word (tbl_rd),
        .merged  (tbl_merged)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rdata  = '0;
        st_d.upd_v  = 1'b0;
        st_d.reeval = 1'b0;
        if (rd_acc) begin
            if (hit_sel) begin
                st_d.rdata = {24'h0, st_q.sel};
            end else if (hit_win) begin
                case (tgt)
                    TGT_ID:  st_d.rdata = 32'(st_q.id) << ID_LSB;
                    TGT_VER: st_d.rdata = VER_WORD;
                    TGT_ENT: st_d.rdata = tbl_rd;
                    default: st_d.rdata = '0;
                endcase
            end
        end
        if (wr_acc) begin
            if (hit_sel) begin
                st_d.sel = acc_wdata[7:0];
            end else if (hit_win) begin
                if (tgt == TGT_ID)
                    st_d.id = acc_wdata[ID_LSB +: ID_W];
                if (tgt == TGT_ENT) begin
                    st_d.upd_v   = 1'b1;
                    st_d.upd_idx = ent_idx;
                    st_d.upd_val = tbl_merged;
                    st_d.reeval  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc_rdata     = st_q.rdata;
    assign ent_upd_valid = st_q.upd_v;
    assign ent_upd_idx   = st_q.upd_idx;
    assign ent_upd_value = st_q.upd_val;
    assign reeval_pulse  = st_q.reeval;

    // R2: a select write is visible in the select register next cycle
    assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr[7:0] == 8'h00) |=> st_q.sel == $past(acc_wdata[7:0]));
    // R4 / R5: window writes with a non-zero index never touch the ID
    assert_id_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_addr[7:0] == 8'h10 && st_q.sel != 8'h00) |=> $stable(st_q.id));
    // R9: the strobe only follows a window write with an entry index
    assert_reeval_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reeval_pulse |-> $past(acc_valid && acc_write && acc_addr[7:0] == 8'h10 && st_q.sel >= 8'h10));
    // R8: the update port never names an entry outside the table
    assert_upd_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ent_upd_valid |-> 32'(ent_upd_idx) < NPINS);
    // R12: read data is zero unless the previous cycle was a read
    assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid && !acc_write) |-> acc_rdata == 32'h0);
endmodule

// File: tb/irq_regwin_tb.sv
`timescale 1ns/1ps
module irq_regwin_tb;
    localparam int NPINS  = 24;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = $clog2(NPINS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [31:0]       acc_wdata = '0;
    logic [31:0]       acc_rdata;
    logic              ent_upd_valid;
    logic [IDX_W-1:0]  ent_upd_idx;
    logic [63:0]       ent_upd_value;
    logic              reeval_pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [63:0] shadow [NPINS];
    logic        s_upd, s_rev;
    logic [IDX_W-1:0] s_idx;
    logic [63:0] s_val;

    always #2.5 clk = ~clk;

    irq_regwin #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dut (
        .clk, .rst_n, .acc_valid, .acc_write, .acc_addr, .acc_wdata,
        .acc_rdata, .ent_upd_valid, .ent_upd_idx, .ent_upd_value, .reeval_pulse
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        s_upd = ent_upd_valid; s_rev = reeval_pulse;
        s_idx = ent_upd_idx;   s_val = ent_upd_value;
        acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0; acc_wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        @(negedge clk);
        d = acc_rdata;
        acc_valid = 1'b0; acc_addr = '0;
    endtask

    task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
        wr(12'h000, {24'h0, s});
        rd(12'h010, d);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h000, v);  check(v, 0, "R10 select after reset");
        rd(12'h010, v);  check(v, 0, "R10 id after reset");
        for (int e = 0; e < NPINS; e += 23) begin
            win_rd(8'(16 + 2 * e), v);     check(v, 32'h0001_0000, "R10 entry low reset");
            win_rd(8'(17 + 2 * e), v);     check(v, 0, "R10 entry high reset");
        end
    endtask

    task automatic t_select_and_id();
        logic [31:0] v;
        wr(12'h000, 32'hFFFF_FF5A);
        rd(12'h000, v);  check(v, 32'h5A, "R2 select readback");
        wr(12'h000, 32'h0);
        wr(12'h010, 32'hFA5C_3210);
        check(s_upd, 0, "R3 id write raises no update");
        rd(12'h010, v);  check(v, 32'h0A00_0000, "R3 id field only");
        rd(12'h110, v);  check(v, 32'h0A00_0000, "R1 upper address bits ignored");
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        win_rd(8'h01, v); check(v, 32'h0017_0011, "R4 version word");
        wr(12'h010, 32'hFFFF_FFFF);
        check(s_rev, 0, "R4 version write no strobe");
        rd(12'h010, v);   check(v, 32'h0017_0011, "R4 version unchanged");
        win_rd(8'h02, v); check(v, 0, "R5 arbitration reads zero");
        wr(12'h010, 32'hFFFF_FFFF);
        rd(12'h010, v);   check(v, 0, "R5 arbitration write ignored");
        win_rd(8'h0B, v); check(v, 0, "R5 gap index reads zero");
        wr(12'h010, 32'h1234_5678);
        check(s_upd, 0, "R5 gap write no update");
        win_rd(8'h00, v); check(v, 32'h0A00_0000, "R5 id untouched by ignored writes");
    endtask

    task automatic t_entries();
        logic [31:0] v;
        wr(12'h000, 32'h16);                // entry 3, low half
        wr(12'h010, 32'hCAFE_00A1);
        shadow[3][31:0] = 32'hCAFE_00A1;
        check(s_upd, 1, "R9 update valid");
        check(s_rev, 1, "R9 reeval strobe");
        check(64'(s_idx), 3, "R9 update index");
        check(s_val, shadow[3], "R9 merged value low write");
        @(negedge clk);
        check(reeval_pulse, 0, "R9 strobe lasts one cycle");
        wr(12'h000, 32'h17);                // entry 3, high half
        wr(12'h010, 32'h0300_0000);
        shadow[3][63:32] = 32'h0300_0000;
        check(s_val, shadow[3], "R7 high write keeps low half");
        win_rd(8'h16, v); check(v, shadow[3][31:0], "R6 even index low half");
        win_rd(8'h17, v); check(v, shadow[3][63:32], "R6 odd index high half");
        wr(12'h000, 32'h3F);                // last entry, high half
        wr(12'h010, 32'hDEAD_BEEF);
        shadow[23][63:32] = 32'hDEAD_BEEF;
        check(64'(s_idx), 23, "R6 last entry index");
        check(s_val, shadow[23], "R7 low half kept at last entry");
        win_rd(8'h18, v); check(v, shadow[4][31:0], "R7 neighbour entry untouched");
        win_rd(8'h3E, v); check(v, shadow[23][31:0], "R7 low half of last entry");
    endtask

    task automatic t_out_of_range();
        logic [31:0] v;
        win_rd(8'h40, v); check(v, 0, "R8 first out-of-range reads zero");
        wr(12'h010, 32'h5555_5555);
        check(s_upd, 0, "R8 no update port");
        check(s_rev, 0, "R8 no strobe");
        win_rd(8'hFF, v); check(v, 0, "R8 top index reads zero");
        win_rd(8'h3F, v); check(v, shadow[23][63:32], "R8 last entry unchanged");
    endtask

    task automatic t_offsets();
        logic [31:0] v;
        wr(12'h000, 32'h16);
        rd(12'h004, v);  check(v, 0, "R11 other offset reads zero");
        wr(12'h020, 32'h0000_0001);
        check(s_rev, 0, "R11 other offset write no strobe");
        rd(12'h000, v);  check(v, 32'h16, "R11 select unchanged");
        rd(12'h010, v);  check(v, shadow[3][31:0], "R11 entry unchanged");
        wr(12'h210, 32'h7777_0000);
        shadow[3][31:0] = 32'h7777_0000;
        check(s_val, shadow[3], "R1 aliased window write");
    endtask

    task automatic t_latency();
        wr(12'h000, 32'h01);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = 12'h010;
        #1 check(acc_rdata, 0, "R12 no data in the access cycle");
        @(negedge clk);
        check(acc_rdata, 32'h0017_0011, "R12 data one cycle later");
        acc_valid = 1'b0; acc_addr = '0;
        @(negedge clk);
        check(acc_rdata, 0, "R12 zero after idle cycle");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < NPINS; i++) shadow[i] = 64'h0000_0000_0001_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_select_and_id();
        t_readonly();
        t_entries();
        t_out_of_range();
        t_offsets();
        t_latency();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule